// File: doc/BRIEF.md
# Configurable Product Term Allocator

This block routes a shared pool of product-term signals to a row of macrocell sum outputs. Each macrocell sees a window of consecutive product terms. A stored selection mask picks which of those terms are ORed into its sum. The sum path is purely combinational. Every macrocell's sum is the same fixed-width AND-OR over its whole window, so the selection never changes the path delay from a term to a sum.

Masks are loaded through a simple write port. The port carries a macrocell index, a mask written in absolute term positions, and a strobe. Before a mask is stored, the block checks three steering and sharing limits:

- the number of selected terms stays within the per-macrocell limit;
- every selected term lies inside the target macrocell's window;
- no selected term is already in use by a macrocell outside the target's group of four.

A write that breaks any rule is dropped and raises an error flag. The flag stays high until a later write is accepted.

Macrocell i has a window of 16 terms. The window starts at term 4*(i/4)+(i%4) and is clipped so it stays inside the pool. Neighbouring windows overlap, so macrocells of the same group can share terms.

Top module: `pta_top`

## Requirements
- R1: After reset every stored mask is all-zero, every sum output is 0 for any product-term input, and the error flag is 0.
- R2: Sum bit i equals the OR of the product terms whose absolute positions are set in macrocell i's stored mask. The sum follows the product-term input in the same cycle, with no register on the path.
- R3: A macrocell whose stored mask is zero drives a sum of 0 whatever the product-term input.
- R4: A write with the strobe high is applied at the first rising clock edge that samples the strobe. Before that edge, the old mask still drives the sum. With the strobe low, no mask changes.
- R5: A mask of up to 16 set bits, all inside macrocell i's window (terms i to i+15 for the default sizes), is accepted and stored.
- R6: A write mask with more than 16 set bits is rejected.
- R7: A write mask with any bit outside the target macrocell's window is rejected. A rejected write leaves every stored mask unchanged.
- R8: A term may be selected by several macrocells of the same group of four (indices 4g to 4g+3). A write selecting a term that a macrocell of another group currently uses is rejected.
- R9: The error flag rises on the edge that samples a rejected write. It holds while the strobe stays low and falls on the edge that samples an accepted write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pt_i | input | 80 | Product-term pool, bit n is term n |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 4 | Target macrocell index |
| cfg_mask_i | input | 80 | Requested terms, bit n selects term n |
| sum_o | output | 16 | Sum per macrocell, bit i is macrocell i |
| cfg_err_o | output | 1 | Last write was rejected |

## Verification
The assertions take for granted that the strobe, index and mask are steady across each rising edge. They also assume that a rejected write is the only event that raises the error flag. The stimulus drives every input on the falling edge and holds it for a full cycle. Each write is a one-cycle pulse, followed by an idle cycle before the next write. The product-term input changes only between edges, so the combinational sums are sampled one time unit after each change.

// File: rtl/pta_pkg.sv
package pta_pkg;

   // first term of a macrocell's window, clipped to the pool
   function automatic int unsigned win_lo(input int unsigned mc,
                                          input int unsigned grp,
                                          input int unsigned n_pt,
                                          input int unsigned win);
      int unsigned s;
      s = grp * (mc / grp) + (mc % grp);
      if (s + win > n_pt) s = n_pt - win;
      return s;
   endfunction

   function automatic int unsigned clog2c(input int unsigned v);
      int unsigned r;
      r = 1;
      while ((1 << r) < v) r++;
      return r;
   endfunction

endpackage

// File: rtl/pta_sum_or.sv
module pta_sum_or
   import pta_pkg::*;
#(
   parameter int unsigned N_MC = 16,
   parameter int unsigned N_PT = 80,
   parameter int unsigned WIN  = 16,
   parameter int unsigned GRP  = 4
) (
   input  logic [N_PT-1:0]          pt_i,
   input  logic [N_MC-1:0][WIN-1:0] mask_i,
   output logic [N_MC-1:0]          sum_o
);
   for (genvar i = 0; i < N_MC; i++) begin : g_mc
      localparam int unsigned LO = win_lo(i, GRP, N_PT, WIN);
      logic [WIN-1:0] sel;
      // every macrocell uses the full window: equal depth for any mask
      assign sel = pt_i[LO +: WIN] & mask_i[i];
      if (WIN > 8) begin : g_split
         localparam int unsigned HALF = WIN / 2;
         logic lo_or, hi_or;
         assign lo_or = |sel[HALF-1:0];
         assign hi_or = |sel[WIN-1:HALF];
         assign sum_o[i] = lo_or | hi_or;
      end else begin : g_flat
         assign sum_o[i] = |sel;
      end
   end
endmodule

// File: rtl/pta_mask_store.sv
module pta_mask_store #(
   parameter int unsigned N_MC = 16,
   parameter int unsigned WIN  = 16,
   parameter int unsigned IDX_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_i,
   input  logic [IDX_W-1:0]         idx_i,
   input  logic [WIN-1:0]           local_mask_i,
   output logic [N_MC-1:0][WIN-1:0] mask_o
);
   for (genvar i = 0; i < N_MC; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask_o[i] <= '0;
         else if (wr_i && (idx_i == IDX_W'(i)))
            mask_o[i] <= local_mask_i;
      end
   end
endmodule

// File: rtl/pta_cfg_check.sv
module pta_cfg_check
   import pta_pkg::*;
#(
   parameter int unsigned N_MC    = 16,
   parameter int unsigned N_PT    = 80,
   parameter int unsigned WIN     = 16,
   parameter int unsigned GRP     = 4,
   parameter int unsigned MAX_SEL = 16,
   parameter int unsigned IDX_W   = 4
) (
   input  logic [N_MC-1:0][WIN-1:0] mask_i,
   input  logic [IDX_W-1:0]         idx_i,
   input  logic [N_PT-1:0]          req_i,
   output logic [WIN-1:0]           local_o,
   output logic                     reject_o
);
   localparam int unsigned NGRP  = N_MC / GRP;
   localparam int unsigned LO_W  = clog2c(N_PT);
   localparam int unsigned CNT_W = clog2c(N_PT + 1) + 1;

   logic [N_MC-1:0][N_PT-1:0] abs_use;
   logic [NGRP-1:0][N_PT-1:0] grp_use;
   logic [N_PT-1:0]           foreign;
   logic [N_PT-1:0]           win_vec;
   logic [LO_W-1:0]           lo_idx;
   logic                      bad_win, bad_cnt, bad_share;

   // absolute term usage of each stored mask
   for (genvar i = 0; i < N_MC; i++) begin : g_abs
      localparam int unsigned LO = win_lo(i, GRP, N_PT, WIN);
      assign abs_use[i] = {{(N_PT-WIN){1'b0}}, mask_i[i]} << LO;
   end

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      always_comb begin
         grp_use[g] = '0;
         for (int k = 0; k < GRP; k++)
            grp_use[g] = grp_use[g] | abs_use[g*GRP + k];
      end
   end

   always_comb begin
      foreign = '0;
      for (int g = 0; g < NGRP; g++)
         if (int'(idx_i) / GRP != g) foreign = foreign | grp_use[g];
   end

   assign lo_idx  = LO_W'(win_lo(int'(idx_i), GRP, N_PT, WIN));
   assign win_vec = {{(N_PT-WIN){1'b0}}, {WIN{1'b1}}} << lo_idx;
   assign bad_win = |(req_i & ~win_vec);
   assign bad_share = |(req_i & foreign);
   assign local_o = WIN'(req_i >> lo_idx);

   if (MAX_SEL >= N_PT) begin : g_no_cnt
      assign bad_cnt = 1'b0;
   end else begin : g_cnt
      logic [CNT_W-1:0] cnt;
      always_comb begin
         cnt = '0;
         for (int n = 0; n < N_PT; n++)
            cnt = cnt + CNT_W'(req_i[n]);
      end
      assign bad_cnt = (cnt > CNT_W'(MAX_SEL));
   end

   assign reject_o = bad_win | bad_cnt | bad_share;
endmodule

// File: rtl/pta_top.sv
module pta_top #(
   parameter int unsigned N_MC    = 16,
   parameter int unsigned N_PT    = 80,
   parameter int unsigned WIN     = 16,
   parameter int unsigned GRP     = 4,
   parameter int unsigned MAX_SEL = 16,
   localparam int unsigned IDX_W  = pta_pkg::clog2c(N_MC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_PT-1:0]  pt_i,
   input  logic             cfg_we_i,
   input  logic [IDX_W-1:0] cfg_idx_i,
   input  logic [N_PT-1:0]  cfg_mask_i,
   output logic [N_MC-1:0]  sum_o,
   output logic             cfg_err_o
);
   if (WIN > N_PT) begin : g_bad_win
      $error("window wider than term pool");
   end
   if (N_MC % GRP != 0) begin : g_bad_grp
      $error("macrocell count must be a multiple of the group size");
   end
   if ((1 << IDX_W) != N_MC) begin : g_bad_idx
      $error("macrocell count must be a power of two");
   end

   logic [N_MC-1:0][WIN-1:0] mask_q;
   logic [WIN-1:0]           wr_local;
   logic                     wr_reject;
   logic                     wr_ok;

   pta_cfg_check #(
      .N_MC(N_MC), .N_PT(N_PT), .WIN(WIN), .GRP(GRP),
      .MAX_SEL(MAX_SEL), .IDX_W(IDX_W)
   ) u_check (
      .mask_i  (mask_q),
      .idx_i   (cfg_idx_i),
      .req_i   (cfg_mask_i),
      .local_o (wr_local),
      .reject_o(wr_reject)
   );

   assign wr_ok = cfg_we_i & ~wr_reject;

   pta_mask_store #(.N_MC(N_MC), .WIN(WIN), .IDX_W(IDX_W)) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_i        (wr_ok),
      .idx_i       (cfg_idx_i),
      .local_mask_i(wr_local),
      .mask_o      (mask_q)
   );

   pta_sum_or #(.N_MC(N_MC), .N_PT(N_PT), .WIN(WIN), .GRP(GRP)) u_sum (
      .pt_i  (pt_i),
      .mask_i(mask_q),
      .sum_o (sum_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_err_o <= 1'b0;
      else if (cfg_we_i) cfg_err_o <= wr_reject;
   end
endmodule

// File: rtl/pta_chk.sv
module pta_chk #(
   parameter int unsigned N_MC = 16,
   parameter int unsigned N_PT = 80,
   parameter int unsigned WIN  = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [N_PT-1:0]          pt_i,
   input logic                     cfg_we_i,
   input logic [N_MC-1:0]          sum_o,
   input logic                     cfg_err_o,
   input logic [N_MC-1:0][WIN-1:0] mask_q,
   input logic                     wr_reject
);
   // R2
   no_terms_no_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pt_i == '0) |-> (sum_o == '0));

   // R4
   idle_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we_i |=> $stable(mask_q));

   // R7
   reject_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we_i && wr_reject) |=> $stable(mask_q));

   // R9
   reject_raises_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we_i && wr_reject) |=> cfg_err_o);

   // R9
   accept_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we_i && !wr_reject) |=> !cfg_err_o);

   // R9
   idle_holds_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we_i |=> $stable(cfg_err_o));

   for (genvar i = 0; i < N_MC; i++) begin : g_zero
      // R3
      empty_mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mask_q[i] == '0) |-> !sum_o[i]);
   end
endmodule

bind pta_top pta_chk #(.N_MC(N_MC), .N_PT(N_PT), .WIN(WIN)) u_chk (
   .clk(clk), .rst_n(rst_n), .pt_i(pt_i), .cfg_we_i(cfg_we_i),
   .sum_o(sum_o), .cfg_err_o(cfg_err_o), .mask_q(mask_q),
   .wr_reject(wr_reject)
);

// File: tb/sim_pta_top.sv
module sim_pta_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [79:0] pt = '0;
   logic        we = 1'b0;
   logic [3:0]  idx = '0;
   logic [79:0] wmask = '0;
   logic [15:0] sum;
   logic        err;

   int checks = 0;
   int errors = 0;
   logic [79:0] model [16];

   always #2 clk = ~clk;

   pta_top u0 (
      .clk(clk), .rst_n(rst_n), .pt_i(pt), .cfg_we_i(we),
      .cfg_idx_i(idx), .cfg_mask_i(wmask), .sum_o(sum), .cfg_err_o(err)
   );

   localparam int NV = 10;
   localparam logic [3:0] V_IDX [NV] = '{4'd0, 4'd1, 4'd2, 4'd4, 4'd4,
                                         4'd15, 4'd0, 4'd0, 4'd5, 4'd8};
   localparam logic [79:0] V_MASK [NV] = '{
      80'h0000_FFFF, 80'h0001_0002, 80'h0000_0002, 80'h0000_8000,
      80'h000E_0000, 80'h7FF0_0000, 80'h0001_FFFF, 80'h0,
      80'h0004_0000, 80'h0004_0000};
   localparam logic V_OK [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1,
                                  1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
   localparam string V_REQ [NV] = '{"R5", "R8", "R7", "R8", "R5",
                                    "R5", "R6", "R3", "R8", "R8"};
   localparam logic [79:0] PATS [4] = '{
      {80{1'b1}}, 80'h5555_5555_5555_5555_5555,
      80'hAAAA_AAAA_AAAA_AAAA_AAAA, 80'h0000_0000_0000_8004_0002};

   function automatic logic [15:0] expect_sum(input logic [79:0] p);
      logic [15:0] e;
      for (int i = 0; i < 16; i++) e[i] = |(p & model[i]);
      return e;
   endfunction

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write(input logic [3:0] i, input logic [79:0] m);
      @(negedge clk);
      idx = i; wmask = m; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic check_pats(input string req);
      for (int p = 0; p < 4; p++) begin
         pt = PATS[p];
         #1;
         check(req, 32'(sum), 32'(expect_sum(PATS[p])));
      end
   endtask

   initial begin
      #40000;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      pt = {80{1'b1}};
      #1;
      check("R1", 32'(sum), 32'h0);
      check("R1", 32'(err), 32'h0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         write(V_IDX[v], V_MASK[v]);
         check(V_REQ[v], 32'(err), 32'(!V_OK[v]));
         if (V_OK[v]) model[V_IDX[v]] = V_MASK[v];
         check_pats("R2");
      end

      // R4: no effect before the sampling edge
      @(negedge clk);
      pt = 80'h8; idx = 4'd3; wmask = 80'h8; we = 1'b1;
      #1;
      check("R4", 32'(sum[3]), 32'h0);
      @(negedge clk);
      we = 1'b0;
      #1;
      check("R4", 32'(sum[3]), 32'h1);
      model[3] = 80'h8;
      // R2: combinational, follows pt without a clock
      pt = 80'h0;
      #1;
      check("R2", 32'(sum), 32'h0);
      pt = 80'h0000_0000_0000_0010_0000;
      #1;
      check("R2", 32'(sum), 32'(expect_sum(pt)));

      // R9: flag holds through idle cycles, clears on accept
      write(4'd9, 80'h1);
      repeat (3) @(negedge clk);
      check("R9", 32'(err), 32'h1);
      // R7: masks unchanged after that reject
      check_pats("R7");
      write(4'd9, 80'h0);
      check("R9", 32'(err), 32'h0);

      // R1: reset clears stored masks
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 16; i++) model[i] = '0;
      pt = {80{1'b1}};
      #1;
      check("R1", 32'(sum), 32'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule